// File: doc/BRIEF.md
# Partitioned Multi-Read Array Storage

This block holds one logical array of `WORDS` elements and spreads it over `BANKS` independent storage banks, so that up to `BANKS` elements can be fetched in the same clock cycle. One write port takes a logical index and a data word. There are `BANKS` read ports, and each one takes an enable and a logical index. Every read port answers exactly one clock after its request. Callers with multi-dimensional arrays flatten their indices before they present them.

The elaboration-time parameter `LAYOUT` picks how logical indices are placed in banks. Blocked placement puts consecutive runs of elements into one bank. Interleaved placement rotates successive elements across the banks. Per-element placement gives every element its own register, so any set of indices can be read at once. In the two banked layouts each bank has a single read path. When several ports ask for the same bank, a fixed priority resolves it and the losing ports are flagged. When `WORDS` is not a multiple of `BANKS`, the trailing banks are shorter.

Top module: `banked_array`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, every `rd_data` lane is zero and `rd_err`/`rd_busy` are low. Every element reads as zero until it is written.
- R2: A write with `wr_en` high and `wr_idx < WORDS` stores `wr_data`. A read of that index returns the stored word on `rd_data` exactly one clock after the request. A read of an index in the same cycle as a write to it returns the previous value.
- R3: With `LAYOUT` = 0 (blocked), element `i` lives in bank `i / RUN` at offset `i % RUN`, where `RUN = ceil(WORDS/BANKS)`.
- R4: With `LAYOUT` = 1 (interleaved), element `i` lives in bank `i % BANKS` at offset `i / BANKS`.
- R5: When `WORDS` is not a multiple of `BANKS`, later banks hold fewer elements. With defaults (10 words, 4 banks), blocked banks hold 3,3,3,1 and interleaved banks hold 3,3,2,2. Every in-range element, including the last, stays readable.
- R6: With `LAYOUT` = 2 (per-element), every enabled in-range read port returns its element, whatever indices the other ports present. `rd_busy` never rises.
- R7: An enabled read with index `>= WORDS` returns zero data with `rd_err` high for that port one clock later. It takes no bank from other ports.
- R8: A write with `wr_idx >= WORDS` changes no element.
- R9: In the banked layouts, when several enabled in-range ports map to one bank, the lowest-numbered port gets the data. Each other port returns zero with `rd_busy` high one clock later. `rd_err` and `rd_busy` are never high together.
- R10: A read port with `rd_en` low returns zero data with both flags low one clock later. It takes no bank from other ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDX_W | Logical write index |
| wr_data | input | DATA_W | Write data |
| rd_en | input | BANKS | Per-port read enable |
| rd_idx | input | BANKS*IDX_W | Logical read indices; port p at bits [p*IDX_W +: IDX_W] |
| rd_data | output | BANKS*DATA_W | Read data; port p at bits [p*DATA_W +: DATA_W] |
| rd_err | output | BANKS | Index of the previous request was out of range |
| rd_busy | output | BANKS | Previous request lost its bank to a lower port |

## Verification
The hardest case to reach from the ports is a mix of bank conflict, out-of-range requests and disabled ports in one cycle. In that case the port that wins is not simply port 0. It is the lowest port that is both enabled and in range. The bench drives three instances, one for each layout, from the same stimulus. Hand-built patterns place a disabled or out-of-range port below a contending one. A long pseudo-random phase then mixes writes, out-of-range indices and partial enables, and a reference model decides the winner of each bank for each layout.

// File: rtl/pab_pkg.sv
package pab_pkg;

    typedef enum logic [1:0] {
        LAYOUT_BLOCK    = 2'd0,
        LAYOUT_CYCLIC   = 2'd1,
        LAYOUT_COMPLETE = 2'd2
    } layout_e;

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    function automatic int width_of(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    // Number of logical elements that land in bank b for a layout.
    function automatic int bank_len(input layout_e lay, input int words,
                                    input int banks, input int b);
        int run;
        int rest;
        run = ceil_div(words, banks);
        if (lay == LAYOUT_CYCLIC) begin
            if (b >= words) return 0;
            return ceil_div(words - b, banks);
        end
        rest = words - b * run;
        if (rest <= 0) return 0;
        return (rest < run) ? rest : run;
    endfunction

endpackage

// File: rtl/pab_index_map.sv
module pab_index_map
    import pab_pkg::*;
#(
    parameter layout_e LAYOUT = LAYOUT_BLOCK,
    parameter int WORDS  = 10,
    parameter int BANKS  = 4,
    parameter int IDX_W  = 5,
    parameter int BANK_W = 2,
    parameter int OFF_W  = 2
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [BANK_W-1:0] bank,
    output logic [OFF_W-1:0]  offset
);
    localparam int RUN = ceil_div(WORDS, BANKS);
    localparam logic [IDX_W-1:0] RUN_L   = IDX_W'(RUN);
    localparam logic [IDX_W-1:0] BANKS_L = IDX_W'(BANKS);

    logic [IDX_W-1:0] quo;
    logic [IDX_W-1:0] rem;

    generate
        if (LAYOUT == LAYOUT_CYCLIC) begin : g_cyclic
            always_comb begin
                quo    = idx / BANKS_L;
                rem    = idx % BANKS_L;
                bank   = BANK_W'(rem);
                offset = OFF_W'(quo);
            end
        end else begin : g_block
            always_comb begin
                quo    = idx / RUN_L;
                rem    = idx % RUN_L;
                bank   = BANK_W'(quo);
                offset = OFF_W'(rem);
            end
        end
    endgenerate
endmodule

// File: rtl/pab_bank.sv
module pab_bank #(
    parameter int DEPTH  = 3,
    parameter int DATA_W = 16,
    parameter int NPORT  = 4,
    parameter int OFF_W  = 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [OFF_W-1:0]                 wr_off,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic [NPORT-1:0]                 req,
    input  logic [NPORT-1:0][OFF_W-1:0]      rd_off,
    output logic [DATA_W-1:0]                rd_q,
    output logic [NPORT-1:0]                 gnt_q
);
    localparam int SLOTS = 1 << OFF_W;

    logic [DATA_W-1:0] mem [SLOTS];
    logic [NPORT-1:0]  gnt;
    logic [OFF_W-1:0]  sel_off;

    // Fixed priority: the lowest requesting port owns the read path.
    always_comb begin
        gnt     = '0;
        sel_off = '0;
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (req[p]) begin
                gnt     = '0;
                gnt[p]  = 1'b1;
                sel_off = rd_off[p];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SLOTS; s++) mem[s] <= '0;
            rd_q  <= '0;
            gnt_q <= '0;
        end else begin
            rd_q  <= (|gnt) ? mem[sel_off] : '0;
            gnt_q <= gnt;
            if (wr_en && (int'(wr_off) < DEPTH)) mem[wr_off] <= wr_data;
        end
    end
endmodule

// File: rtl/pab_reg_file.sv
module pab_reg_file #(
    parameter int WORDS  = 10,
    parameter int DATA_W = 16,
    parameter int NPORT  = 4,
    parameter int IDX_W  = 5
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic [NPORT-1:0]                 rd_en,
    input  logic [NPORT-1:0][IDX_W-1:0]      rd_idx,
    output logic [NPORT-1:0][DATA_W-1:0]     rd_q
);
    localparam int SLOTS = 1 << IDX_W;

    logic [DATA_W-1:0] elems [SLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SLOTS; s++) elems[s] <= '0;
        end else if (wr_en && (int'(wr_idx) < WORDS)) begin
            elems[wr_idx] <= wr_data;
        end
    end

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            always_ff @(posedge clk) begin
                if (rst) begin
                    rd_q[p] <= '0;
                end else begin
                    rd_q[p] <= (rd_en[p] && (int'(rd_idx[p]) < WORDS))
                               ? elems[rd_idx[p]] : '0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/banked_array.sv
module banked_array
    import pab_pkg::*;
#(
    parameter layout_e LAYOUT = LAYOUT_BLOCK,
    parameter int WORDS  = 10,
    parameter int BANKS  = 4,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(WORDS) + 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [BANKS-1:0]          rd_en,
    input  logic [BANKS*IDX_W-1:0]    rd_idx,
    output logic [BANKS*DATA_W-1:0]   rd_data,
    output logic [BANKS-1:0]          rd_err,
    output logic [BANKS-1:0]          rd_busy
);
    localparam int NPORT  = BANKS;
    localparam int RUN    = ceil_div(WORDS, BANKS);
    localparam int BANK_W = width_of(BANKS);
    localparam int OFF_W  = width_of(RUN);

    logic [NPORT-1:0][IDX_W-1:0]  idx_v;
    logic [NPORT-1:0]             in_range;
    logic [NPORT-1:0]             err_q;
    logic [NPORT-1:0][DATA_W-1:0] port_data;

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            idx_v[p]    = rd_idx[p*IDX_W +: IDX_W];
            in_range[p] = int'(idx_v[p]) < WORDS;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= '0;
        else     err_q <= rd_en & ~in_range;
    end

    assign rd_err = err_q;

    always_comb begin
        for (int p = 0; p < NPORT; p++) rd_data[p*DATA_W +: DATA_W] = port_data[p];
    end

    generate
        if (LAYOUT == LAYOUT_COMPLETE) begin : g_regs
            pab_reg_file #(
                .WORDS (WORDS),
                .DATA_W(DATA_W),
                .NPORT (NPORT),
                .IDX_W (IDX_W)
            ) u_regs (
                .clk    (clk),
                .rst    (rst),
                .wr_en  (wr_en),
                .wr_idx (wr_idx),
                .wr_data(wr_data),
                .rd_en  (rd_en),
                .rd_idx (idx_v),
                .rd_q   (port_data)
            );
            assign rd_busy = '0;
        end else begin : g_banked
            logic [BANK_W-1:0]             wr_bank;
            logic [OFF_W-1:0]              wr_off;
            logic [NPORT-1:0][BANK_W-1:0]  rd_bank;
            logic [NPORT-1:0][OFF_W-1:0]   rd_off;
            logic [BANKS-1:0][DATA_W-1:0]  bank_q;
            logic [BANKS-1:0][NPORT-1:0]   bank_gnt;
            logic [NPORT-1:0]              req_q;
            logic [NPORT-1:0]              hit;

            pab_index_map #(
                .LAYOUT(LAYOUT), .WORDS(WORDS), .BANKS(BANKS),
                .IDX_W(IDX_W), .BANK_W(BANK_W), .OFF_W(OFF_W)
            ) u_wr_map (
                .idx   (wr_idx),
                .bank  (wr_bank),
                .offset(wr_off)
            );

            for (genvar p = 0; p < NPORT; p++) begin : g_rmap
                pab_index_map #(
                    .LAYOUT(LAYOUT), .WORDS(WORDS), .BANKS(BANKS),
                    .IDX_W(IDX_W), .BANK_W(BANK_W), .OFF_W(OFF_W)
                ) u_rd_map (
                    .idx   (idx_v[p]),
                    .bank  (rd_bank[p]),
                    .offset(rd_off[p])
                );
            end

            for (genvar b = 0; b < BANKS; b++) begin : g_bank
                localparam int LEN   = bank_len(LAYOUT, WORDS, BANKS, b);
                localparam int DEPTH = (LEN < 1) ? 1 : LEN;
                logic [NPORT-1:0] req;
                logic             bank_we;

                always_comb begin
                    for (int p = 0; p < NPORT; p++) begin
                        req[p] = rd_en[p] && in_range[p] && (rd_bank[p] == BANK_W'(b));
                    end
                    bank_we = wr_en && (int'(wr_idx) < WORDS) && (LEN > 0)
                              && (wr_bank == BANK_W'(b));
                end

                pab_bank #(
                    .DEPTH (DEPTH),
                    .DATA_W(DATA_W),
                    .NPORT (NPORT),
                    .OFF_W (OFF_W)
                ) u_bank (
                    .clk    (clk),
                    .rst    (rst),
                    .wr_en  (bank_we),
                    .wr_off (wr_off),
                    .wr_data(wr_data),
                    .req    (req),
                    .rd_off (rd_off),
                    .rd_q   (bank_q[b]),
                    .gnt_q  (bank_gnt[b])
                );
            end

            always_ff @(posedge clk) begin
                if (rst) req_q <= '0;
                else     req_q <= rd_en & in_range;
            end

            always_comb begin
                for (int p = 0; p < NPORT; p++) begin
                    port_data[p] = '0;
                    hit[p]       = 1'b0;
                    for (int b = 0; b < BANKS; b++) begin
                        if (bank_gnt[b][p]) begin
                            port_data[p] = port_data[p] | bank_q[b];
                            hit[p]       = 1'b1;
                        end
                    end
                end
            end

            assign rd_busy = req_q & ~hit;
        end
    endgenerate
endmodule

// File: rtl/banked_array_checker.sv
module banked_array_checker
    import pab_pkg::*;
#(
    parameter layout_e LAYOUT = LAYOUT_BLOCK,
    parameter int WORDS  = 10,
    parameter int BANKS  = 4,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 5
) (
    input logic                    clk,
    input logic                    rst,
    input logic [BANKS-1:0]        rd_en,
    input logic [BANKS*IDX_W-1:0]  rd_idx,
    input logic [BANKS*DATA_W-1:0] rd_data,
    input logic [BANKS-1:0]        rd_err,
    input logic [BANKS-1:0]        rd_busy
);
    generate
        for (genvar p = 0; p < BANKS; p++) begin : g_chk
            // R7: out-of-range request answers zero with the error flag
            assert_range_err_R7: assert property (@(posedge clk) disable iff (rst)
                (rd_en[p] && (int'(rd_idx[p*IDX_W +: IDX_W]) >= WORDS))
                |=> (rd_err[p] && (rd_data[p*DATA_W +: DATA_W] == '0)));

            // R10: an idle port stays silent
            assert_idle_port_R10: assert property (@(posedge clk) disable iff (rst)
                !rd_en[p] |=> (!rd_err[p] && !rd_busy[p]
                               && (rd_data[p*DATA_W +: DATA_W] == '0)));

            // R9: the two flags are exclusive
            assert_flags_excl_R9: assert property (@(posedge clk) disable iff (rst)
                $onehot0({rd_err[p], rd_busy[p]}));

            // R9: a losing port drives zero data
            assert_busy_zero_R9: assert property (@(posedge clk) disable iff (rst)
                rd_busy[p] |-> (rd_data[p*DATA_W +: DATA_W] == '0));
        end

        if (LAYOUT == LAYOUT_COMPLETE) begin : g_full
            // R6: per-element storage never reports a conflict
            assert_no_conflict_R6: assert property (@(posedge clk) disable iff (rst)
                rd_busy == '0);
        end
    endgenerate

    // R9: port 0 always wins its bank
    assert_port0_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en[0] && (int'(rd_idx[IDX_W-1:0]) < WORDS)) |=> !rd_busy[0]);
endmodule

bind banked_array banked_array_checker #(
    .LAYOUT(LAYOUT),
    .WORDS (WORDS),
    .BANKS (BANKS),
    .DATA_W(DATA_W),
    .IDX_W (IDX_W)
) u_checker (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_en),
    .rd_idx (rd_idx),
    .rd_data(rd_data),
    .rd_err (rd_err),
    .rd_busy(rd_busy)
);

// File: tb/banked_array_bench.sv
module banked_array_bench;
    import pab_pkg::*;

    localparam int N  = 10;
    localparam int F  = 4;
    localparam int DW = 16;
    localparam int IW = $clog2(N) + 1;
    localparam int RUNLEN = (N + F - 1) / F;

    typedef struct packed {
        logic [2:0][F-1:0][DW-1:0] d;
        logic [2:0][F-1:0]         e;
        logic [2:0][F-1:0]         b;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               wr_en = 1'b0;
    logic [IW-1:0]      wr_idx = '0;
    logic [DW-1:0]      wr_data = '0;
    logic [F-1:0]       rd_en = '0;
    logic [F*IW-1:0]    rd_idx = '0;
    logic [F*DW-1:0]    rdat [3];
    logic [F-1:0]       rerr [3];
    logic [F-1:0]       rbusy [3];

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] model [N];
    exp_t  exp_q [$];
    string tag_q [$];
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    banked_array #(.LAYOUT(LAYOUT_BLOCK), .WORDS(N), .BANKS(F), .DATA_W(DW)) u_banked_array (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rdat[0]), .rd_err(rerr[0]), .rd_busy(rbusy[0]));

    banked_array #(.LAYOUT(LAYOUT_CYCLIC), .WORDS(N), .BANKS(F), .DATA_W(DW)) u_banked_array_cyc (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rdat[1]), .rd_err(rerr[1]), .rd_busy(rbusy[1]));

    banked_array #(.LAYOUT(LAYOUT_COMPLETE), .WORDS(N), .BANKS(F), .DATA_W(DW)) u_banked_array_cmp (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rdat[2]), .rd_err(rerr[2]), .rd_busy(rbusy[2]));

    // R3 / R4 / R6 placement rules, written from the requirements
    function automatic int ref_bank(input int mode, input int idx);
        if (mode == 0) return idx / RUNLEN;
        if (mode == 1) return idx % F;
        return idx;
    endfunction

    task automatic drive(input bit we, input int widx, input int wdat,
                         input logic [F-1:0] en, input int i0, input int i1,
                         input int i2, input int i3, input string tag);
        int   ix [F];
        exp_t ex;
        ix[0] = i0; ix[1] = i1; ix[2] = i2; ix[3] = i3;
        @(negedge clk);
        wr_en   = we;
        wr_idx  = IW'(widx);
        wr_data = DW'(wdat);
        rd_en   = en;
        for (int p = 0; p < F; p++) rd_idx[p*IW +: IW] = IW'(ix[p]);
        ex = '0;
        for (int m = 0; m < 3; m++) begin
            bit taken [N];
            for (int k = 0; k < N; k++) taken[k] = 1'b0;
            for (int p = 0; p < F; p++) begin
                if (!en[p]) continue;
                if (ix[p] >= N) begin
                    ex.e[m][p] = 1'b1;
                end else if (m != 2 && taken[ref_bank(m, ix[p])]) begin
                    ex.b[m][p] = 1'b1;
                end else begin
                    if (m != 2) taken[ref_bank(m, ix[p])] = 1'b1;
                    ex.d[m][p] = model[ix[p]];
                end
            end
        end
        exp_q.push_back(ex);
        tag_q.push_back(tag);
        if (we && widx < N) model[widx] = DW'(wdat);
    endtask

    // Monitor: compare one expected item per cycle, just after the edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t  ex;
            string tg;
            ex = exp_q.pop_front();
            tg = tag_q.pop_front();
            for (int m = 0; m < 3; m++) begin
                for (int p = 0; p < F; p++) begin
                    checks++;
                    if (rdat[m][p*DW +: DW] !== ex.d[m][p] || rerr[m][p] !== ex.e[m][p]
                        || rbusy[m][p] !== ex.b[m][p]) begin
                        errors++;
                        $display("FAIL %s layout %0d port %0d: got d=%h e=%b b=%b, expected d=%h e=%b b=%b",
                                 tg, m, p, rdat[m][p*DW +: DW], rerr[m][p], rbusy[m][p],
                                 ex.d[m][p], ex.e[m][p], ex.b[m][p]);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got hang, expected completion");
        finish_run();
    end

    initial begin
        for (int k = 0; k < N; k++) model[k] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: outputs idle right after reset
        for (int m = 0; m < 3; m++) begin
            checks++;
            if (rdat[m] !== '0 || rerr[m] !== '0 || rbusy[m] !== '0) begin
                errors++;
                $display("FAIL R1 layout %0d: got d=%h e=%b b=%b, expected zeros",
                         m, rdat[m], rerr[m], rbusy[m]);
            end
        end
        drive(0, 0, 0, 4'b1111, 0, 3, 6, 9, "R1");
        drive(0, 0, 0, 4'b1111, 1, 4, 7, 8, "R1");

        // R2: fill, then read back one index at a time on port 0
        for (int i = 0; i < N; i++) drive(1, i, 16'h1100 + i * 37, 4'b0000, 0, 0, 0, 0, "R2");
        for (int i = 0; i < N; i++) drive(0, 0, 0, 4'b0001, i, 0, 0, 0, "R2");
        drive(1, 5, 16'hABCD, 4'b0001, 5, 0, 0, 0, "R2");
        drive(0, 0, 0, 4'b0001, 5, 0, 0, 0, "R2");

        drive(0, 0, 0, 4'b1111, 0, 1, 2, 5, "R3");
        drive(0, 0, 0, 4'b1111, 0, 3, 6, 9, "R3");
        drive(0, 0, 0, 4'b1111, 0, 4, 8, 1, "R4");
        drive(0, 0, 0, 4'b1111, 3, 2, 1, 0, "R4");
        drive(0, 0, 0, 4'b1111, 9, 8, 7, 6, "R5");
        drive(0, 0, 0, 4'b1111, 9, 2, 5, 8, "R5");
        drive(0, 0, 0, 4'b1111, 3, 3, 3, 3, "R6");
        drive(0, 0, 0, 4'b1111, 12, 0, 15, 10, "R7");
        drive(0, 0, 0, 4'b1111, 31, 1, 1, 2, "R7");
        drive(0, 0, 0, 4'b1010, 0, 0, 0, 0, "R10");
        drive(0, 0, 0, 4'b0000, 1, 2, 3, 4, "R10");
        drive(0, 0, 0, 4'b1110, 9, 9, 9, 9, "R9");

        // R8: out-of-range writes leave every element unchanged
        drive(1, 13, 16'hFFFF, 4'b0000, 0, 0, 0, 0, "R8");
        drive(1, 31, 16'hEEEE, 4'b0000, 0, 0, 0, 0, "R8");
        drive(1, 10, 16'hDDDD, 4'b0000, 0, 0, 0, 0, "R8");
        drive(0, 0, 0, 4'b1111, 0, 3, 6, 9, "R8");
        drive(0, 0, 0, 4'b1111, 1, 4, 7, 2, "R8");
        drive(0, 0, 0, 4'b1111, 5, 8, 0, 0, "R8");

        // R9: mixed traffic with conflicts, gaps and out-of-range indices
        for (int c = 0; c < 400; c++) begin
            int v [F];
            for (int p = 0; p < F; p++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                v[p] = int'(lfsr[3:0]);
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive(lfsr[0], int'(lfsr[4:1]), int'(lfsr), lfsr[8:5],
                  v[0], v[1], v[2], v[3], "R9");
        end

        @(negedge clk);
        rd_en = '0;
        wr_en = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        finish_run();
    end
endmodule